// File: doc/BRIEF.md
# Flash Geometry Query Reader

This engine walks a chain of 16-bit parallel NOR flash dies that sit one after another in the address map. For each die it clears the status register and enters query mode. It then fetches the standard query table one word at a time and checks the three-word signature. From the table it builds a geometry record: the die's start address, its size in bytes, the write-buffer depth in words, and the block count and block size of two erase regions. Finally it returns the die to read-array mode and moves to the next die, whose base is the current base plus the size just decoded.

Software or a boot sequencer pulses `start` with the first die's base address and the number of dies. The engine then runs alone, with one bus access in flight at a time. A `rec_valid` strobe marks each finished record. `done` pulses once when the walk is over. If a signature word is wrong, the engine parks that die in read-array mode, raises `sig_err` and ends the walk.

Top module: `flash_geom_reader`

## Requirements
- R1: During and after a synchronous reset, `fl_we`, `fl_re`, `busy`, `done`, `sig_err` and `rec_valid` are low.
- R2: Each die starts with a write of 0x0050 and then a write of 0x0098, both at the die base address. Each write drives `fl_we` for exactly one cycle.
- R3: Reads go to byte address base + 2×offset. The word offsets come in this order: 0x10, 0x11, 0x12, 0x27, 0x2A, 0x2D, 0x2E, 0x2F, 0x30, 0x31, 0x32, 0x33, 0x34. No other bus access takes place.
- R4: Each read holds `fl_re` and a steady `fl_addr` for exactly RD_WAIT cycles and samples `fl_rdata` in the last of them. `fl_re` and `fl_we` are never high together.
- R5: Offsets 0x10, 0x11 and 0x12 must return the full 16-bit words 0x0051, 0x0052 and 0x0059. On the first mismatch, no further read is made. The engine writes 0x00FF at the die base, produces no record for that die, skips all later dies, and raises `sig_err` in the same cycle as `done`.
- R6: After the last table read, the engine writes 0x00FF at the die base. `rec_valid` pulses for one cycle, two cycles after that write strobe.
- R7: `rec_size` is 2^e, where e is the low byte read at 0x27. `rec_wbuf_words` is 2^w / 2, where w is the low byte at 0x2A.
- R8: A region's block count is the 16-bit little-endian value plus one: low byte from 0x2D, high byte from 0x2E for region 1; 0x31 and 0x32 for region 2. Only the low byte of each read is used.
- R9: A region's block size in bytes is 256 times the 16-bit little-endian value: 0x2F and 0x30 for region 1, 0x33 and 0x34 for region 2. Only the low byte of each read is used.
- R10: The first die is at `first_base`. Each next die's base is the previous base plus the previous `rec_size`. `rec_die` counts from 0.
- R11: `done` is a one-cycle pulse. It comes in the same cycle as the last die's `rec_valid`, or two cycles after the 0x00FF write of an aborted die. With `die_count` of 0 it comes in the cycle after `start`, with no bus access. `busy` is low from the `done` cycle on.
- R12: The record outputs change only when `rec_valid` is high. `sig_err` holds until the next accepted `start`, which clears it. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| first_base | input | AW | Byte address of the first die |
| die_count | input | CW | Number of dies to walk |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | Read enable, held for the access time |
| fl_rdata | input | 16 | Flash read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| sig_err | output | 1 | Signature mismatch seen in the last walk |
| rec_valid | output | 1 | One-cycle strobe: new record on the rec_* ports |
| rec_die | output | CW | Die index of the record |
| rec_base | output | AW | Die start address |
| rec_size | output | AW | Die size in bytes |
| rec_wbuf_words | output | AW | Write-buffer depth in 16-bit words |
| rec_r1_blocks | output | 17 | Region 1 block count |
| rec_r1_bytes | output | 24 | Region 1 block size in bytes |
| rec_r2_blocks | output | 17 | Region 2 block count |
| rec_r2_bytes | output | 24 | Region 2 block size in bytes |

## Verification
The timing of every result is fixed:
- A write strobe appears one cycle after its request, and requests are three cycles apart.
- A read holds `fl_re` for RD_WAIT cycles.
- A record strobe, and the `done` of an abort, land exactly two cycles after the cycle in which the 0x00FF write strobe is seen.
- With no dies, `done` lands one cycle after `start`.

The bench keeps a timer that is armed when it sees that write strobe, or when it raises `start`. It compares `rec_valid`, `done` and `sig_err` on every clock against the timer's expectation. Its flash model returns a poison word until `fl_re` has been held for RD_WAIT cycles, so a sample taken one cycle early breaks the signature and shows up as an unexpected bus operation.

// File: rtl/fgr_pkg.sv
package fgr_pkg;

  localparam int          NFIELD      = 10;
  localparam int          FIRST_FIELD = 3;
  localparam logic [3:0]  LAST_STEP   = 4'd12;
  localparam int          BLK_W       = 17;
  localparam int          BSZ_W       = 24;

  localparam logic [15:0] CMD_CLR = 16'h0050;
  localparam logic [15:0] CMD_QRY = 16'h0098;
  localparam logic [15:0] CMD_ARR = 16'h00FF;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_CLR,
    FS_QRY,
    FS_READ,
    FS_ARR
  } fgr_state_t;

  // word offset visited by each read step
  function automatic logic [7:0] step_offset(input logic [3:0] s);
    case (s)
      4'd0:    return 8'h10;
      4'd1:    return 8'h11;
      4'd2:    return 8'h12;
      4'd3:    return 8'h27;
      4'd4:    return 8'h2A;
      4'd5:    return 8'h2D;
      4'd6:    return 8'h2E;
      4'd7:    return 8'h2F;
      4'd8:    return 8'h30;
      4'd9:    return 8'h31;
      4'd10:   return 8'h32;
      4'd11:   return 8'h33;
      4'd12:   return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  // signature word expected at the first three steps
  function automatic logic [15:0] sig_word(input logic [3:0] s);
    case (s)
      4'd0:    return 16'h0051;
      4'd1:    return 16'h0052;
      4'd2:    return 16'h0059;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/fgr_bus_port.sv
module fgr_bus_port #(
  parameter int AW      = 32,
  parameter int RD_WAIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          ack,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [15:0]   fl_rdata
);

  localparam int WW = (RD_WAIT < 2) ? 1 : $clog2(RD_WAIT + 1);
  localparam logic [WW-1:0] LAST_CNT = WW'(RD_WAIT - 1);

  typedef enum logic [1:0] {E_IDLE, E_WR, E_RD} eng_t;
  eng_t          est;
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      est      <= E_IDLE;
      cnt      <= '0;
      ack      <= 1'b0;
      rd_data  <= '0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (est)
        E_IDLE: if (req) begin
          fl_addr <= req_addr;
          cnt     <= '0;
          if (req_wr) begin
            fl_wdata <= req_wdata;
            fl_we    <= 1'b1;
            est      <= E_WR;
          end else begin
            fl_re <= 1'b1;
            est   <= E_RD;
          end
        end
        E_WR: begin
          fl_we <= 1'b0;
          ack   <= 1'b1;
          est   <= E_IDLE;
        end
        E_RD: begin
          if (cnt == LAST_CNT) begin
            rd_data <= fl_rdata;
            fl_re   <= 1'b0;
            ack     <= 1'b1;
            est     <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: est <= E_IDLE;
      endcase
    end
  end

  // run length of the read strobe, for checking only
  logic [WW:0] re_run;
  always_ff @(posedge clk) begin
    if (rst)        re_run <= '0;
    else if (fl_re) re_run <= re_run + 1'b1;
    else            re_run <= '0;
  end

  assert_we_single_R2: assert property (@(posedge clk) disable iff (rst)
    fl_we |=> !fl_we);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));
  assert_rd_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    fl_re |=> (!fl_re || $stable(fl_addr)));
  assert_rd_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_re) |-> (re_run == (WW+1)'(RD_WAIT)));

endmodule

// File: rtl/fgr_field_asm.sv
module fgr_field_asm
  import fgr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [3:0]       cap_step,
  input  logic [7:0]       cap_byte,
  output logic [AW-1:0]    dev_size,
  output logic [AW-1:0]    wbuf_words,
  output logic [BLK_W-1:0] r1_blocks,
  output logic [BSZ_W-1:0] r1_bytes,
  output logic [BLK_W-1:0] r2_blocks,
  output logic [BSZ_W-1:0] r2_bytes
);

  localparam logic [7:0] AW8 = 8'(AW);

  logic [NFIELD*8-1:0] flat;

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (cap && cap_step == 4'(FIRST_FIELD + gi))
        q <= cap_byte;
    end
    assign flat[gi*8 +: 8] = q;
  end

  logic [7:0]    e_size, e_wbuf;
  logic [AW-1:0] wbuf_bytes;

  assign e_size = flat[0*8 +: 8];
  assign e_wbuf = flat[1*8 +: 8];

  always_comb begin
    dev_size   = (e_size < AW8) ? (AW'(1) << e_size) : '0;
    wbuf_bytes = (e_wbuf < AW8) ? (AW'(1) << e_wbuf) : '0;
    wbuf_words = wbuf_bytes >> 1;
    r1_blocks  = {1'b0, flat[3*8 +: 8], flat[2*8 +: 8]} + 17'd1;
    r1_bytes   = {flat[5*8 +: 8], flat[4*8 +: 8], 8'h00};
    r2_blocks  = {1'b0, flat[7*8 +: 8], flat[6*8 +: 8]} + 17'd1;
    r2_bytes   = {flat[9*8 +: 8], flat[8*8 +: 8], 8'h00};
  end

  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    cap |-> (cap_step <= LAST_STEP));

endmodule

// File: rtl/flash_geom_reader.sv
module flash_geom_reader
  import fgr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 4,
  parameter int RD_WAIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    first_base,
  input  logic [CW-1:0]    die_count,
  output logic [AW-1:0]    fl_addr,
  output logic [15:0]      fl_wdata,
  output logic             fl_we,
  output logic             fl_re,
  input  logic [15:0]      fl_rdata,
  output logic             busy,
  output logic             done,
  output logic             sig_err,
  output logic             rec_valid,
  output logic [CW-1:0]    rec_die,
  output logic [AW-1:0]    rec_base,
  output logic [AW-1:0]    rec_size,
  output logic [AW-1:0]    rec_wbuf_words,
  output logic [BLK_W-1:0] rec_r1_blocks,
  output logic [BSZ_W-1:0] rec_r1_bytes,
  output logic [BLK_W-1:0] rec_r2_blocks,
  output logic [BSZ_W-1:0] rec_r2_bytes
);

  fgr_state_t    st;
  logic          waiting;
  logic [3:0]    step;
  logic [CW-1:0] die, total;
  logic [AW-1:0] base;
  logic          err;

  logic          req, req_wr, ack, sig_bad;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata, rd_data;

  logic [AW-1:0]    d_size, d_wbuf;
  logic [BLK_W-1:0] d_r1_blk, d_r2_blk;
  logic [BSZ_W-1:0] d_r1_sz, d_r2_sz;

  always_comb begin
    req    = (st != FS_IDLE) && !waiting;
    req_wr = (st != FS_READ);
    case (st)
      FS_CLR:  req_wdata = CMD_CLR;
      FS_QRY:  req_wdata = CMD_QRY;
      default: req_wdata = CMD_ARR;
    endcase
    req_addr = (st == FS_READ) ? base + AW'({step_offset(step), 1'b0}) : base;
    sig_bad  = (step < 4'd3) && (rd_data != sig_word(step));
  end

  fgr_bus_port #(.AW(AW), .RD_WAIT(RD_WAIT)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack       (ack),
    .rd_data   (rd_data),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .fl_we     (fl_we),
    .fl_re     (fl_re),
    .fl_rdata  (fl_rdata)
  );

  fgr_field_asm #(.AW(AW)) u_fields (
    .clk        (clk),
    .rst        (rst),
    .cap        (ack && st == FS_READ),
    .cap_step   (step),
    .cap_byte   (rd_data[7:0]),
    .dev_size   (d_size),
    .wbuf_words (d_wbuf),
    .r1_blocks  (d_r1_blk),
    .r1_bytes   (d_r1_sz),
    .r2_blocks  (d_r2_blk),
    .r2_bytes   (d_r2_sz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= FS_IDLE;
      waiting        <= 1'b0;
      step           <= '0;
      die            <= '0;
      total          <= '0;
      base           <= '0;
      err            <= 1'b0;
      busy           <= 1'b0;
      done           <= 1'b0;
      sig_err        <= 1'b0;
      rec_valid      <= 1'b0;
      rec_die        <= '0;
      rec_base       <= '0;
      rec_size       <= '0;
      rec_wbuf_words <= '0;
      rec_r1_blocks  <= '0;
      rec_r1_bytes   <= '0;
      rec_r2_blocks  <= '0;
      rec_r2_bytes   <= '0;
    end else begin
      done      <= 1'b0;
      rec_valid <= 1'b0;
      if (req) waiting <= 1'b1;
      case (st)
        FS_IDLE: if (start) begin
          sig_err <= 1'b0;
          if (die_count == '0) begin
            done <= 1'b1;
          end else begin
            st    <= FS_CLR;
            base  <= first_base;
            die   <= '0;
            total <= die_count;
            err   <= 1'b0;
            busy  <= 1'b1;
          end
        end
        FS_CLR: if (ack) begin
          waiting <= 1'b0;
          st      <= FS_QRY;
        end
        FS_QRY: if (ack) begin
          waiting <= 1'b0;
          step    <= '0;
          st      <= FS_READ;
        end
        FS_READ: if (ack) begin
          waiting <= 1'b0;
          if (sig_bad) begin
            err <= 1'b1;
            st  <= FS_ARR;
          end else if (step == LAST_STEP) begin
            st <= FS_ARR;
          end else begin
            step <= step + 1'b1;
          end
        end
        FS_ARR: if (ack) begin
          waiting <= 1'b0;
          if (err) begin
            sig_err <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            st      <= FS_IDLE;
          end else begin
            rec_valid      <= 1'b1;
            rec_die        <= die;
            rec_base       <= base;
            rec_size       <= d_size;
            rec_wbuf_words <= d_wbuf;
            rec_r1_blocks  <= d_r1_blk;
            rec_r1_bytes   <= d_r1_sz;
            rec_r2_blocks  <= d_r2_blk;
            rec_r2_bytes   <= d_r2_sz;
            base           <= base + d_size;
            if (die == total - 1'b1) begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= FS_IDLE;
            end else begin
              die <= die + 1'b1;
              st  <= FS_CLR;
            end
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && st == FS_IDLE));
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_err) |-> done);
  assert_rec_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> ($stable(rec_size) && $stable(rec_base) && $stable(rec_r1_blocks)));
  assert_no_bus_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == FS_IDLE && !busy) |=> !fl_re);

endmodule

// File: tb/tb_flash_geom_reader.sv
module tb_flash_geom_reader;

  localparam int AW = 32;
  localparam int CW = 4;
  localparam int RD_WAIT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] first_base = '0;
  logic [CW-1:0] die_count = '0;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_wdata;
  logic fl_we, fl_re;
  logic [15:0] fdata = 16'hBAD0;
  logic busy, done, sig_err, rec_valid;
  logic [CW-1:0] rec_die;
  logic [AW-1:0] rec_base, rec_size, rec_wbuf_words;
  logic [16:0] rec_r1_blocks, rec_r2_blocks;
  logic [23:0] rec_r1_bytes, rec_r2_bytes;

  always #5 clk = ~clk;

  flash_geom_reader #(.AW(AW), .CW(CW), .RD_WAIT(RD_WAIT)) dut (
    .clk(clk), .rst(rst), .start(start), .first_base(first_base), .die_count(die_count),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fdata),
    .busy(busy), .done(done), .sig_err(sig_err), .rec_valid(rec_valid), .rec_die(rec_die),
    .rec_base(rec_base), .rec_size(rec_size), .rec_wbuf_words(rec_wbuf_words),
    .rec_r1_blocks(rec_r1_blocks), .rec_r1_bytes(rec_r1_bytes),
    .rec_r2_blocks(rec_r2_blocks), .rec_r2_bytes(rec_r2_bytes)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // die configuration (bench flash contents)
  int          n_cfg = 0;
  int          cfg_e[4], cfg_w[4];
  logic [15:0] cfg_c1[4], cfg_s1[4], cfg_c2[4], cfg_s2[4];
  logic [15:0] cfg_sig[4][3];
  longint      cfg_base[4];
  bit          qm[4];

  function automatic logic [15:0] tval(input int d, input int off);
    case (off)
      'h10: return cfg_sig[d][0];
      'h11: return cfg_sig[d][1];
      'h12: return cfg_sig[d][2];
      'h27: return {8'hA5, 8'(cfg_e[d])};
      'h2A: return {8'h3C, 8'(cfg_w[d])};
      'h2D: return {8'h7E, cfg_c1[d][7:0]};
      'h2E: return {8'h81, cfg_c1[d][15:8]};
      'h2F: return {8'hC3, cfg_s1[d][7:0]};
      'h30: return {8'h5A, cfg_s1[d][15:8]};
      'h31: return {8'h99, cfg_c2[d][7:0]};
      'h32: return {8'h66, cfg_c2[d][15:8]};
      'h33: return {8'hE7, cfg_s2[d][7:0]};
      'h34: return {8'h18, cfg_s2[d][15:8]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int find_die(input logic [31:0] a);
    for (int d = 0; d < n_cfg; d++)
      if (longint'(a) >= cfg_base[d] && longint'(a) < cfg_base[d] + (longint'(1) << cfg_e[d]))
        return d;
    return -1;
  endfunction

  task automatic set_die(input int d, input int e, input int w, input logic [15:0] c1,
                         input logic [15:0] s1, input logic [15:0] c2, input logic [15:0] s2);
    cfg_e[d] = e; cfg_w[d] = w; cfg_c1[d] = c1; cfg_s1[d] = s1; cfg_c2[d] = c2; cfg_s2[d] = s2;
    cfg_sig[d][0] = 16'h0051; cfg_sig[d][1] = 16'h0052; cfg_sig[d][2] = 16'h0059;
  endtask

  // expected bus ops and records
  bit          q_w[$];
  logic [31:0] q_a[$];
  logic [15:0] q_d[$];
  int          q_k[$];
  logic [31:0] x_base[$], x_size[$], x_wb[$];
  logic [16:0] x_c1[$], x_c2[$];
  logic [23:0] x_s1[$], x_s2[$];
  int          x_die[$];

  task automatic push_op(input bit w, input logic [31:0] a, input logic [15:0] d, input int k);
    q_w.push_back(w); q_a.push_back(a); q_d.push_back(d); q_k.push_back(k);
  endtask

  task automatic plan(input logic [31:0] b, input int n);
    longint cur = longint'(b);
    int offs[13] = '{'h10, 'h11, 'h12, 'h27, 'h2A, 'h2D, 'h2E, 'h2F, 'h30, 'h31, 'h32, 'h33, 'h34};
    logic [15:0] sigx[3] = '{16'h0051, 16'h0052, 16'h0059};
    bit stop = 0;
    n_cfg = n;
    for (int d = 0; d < n; d++) begin
      if (!stop) begin
        bit abort = 0;
        cfg_base[d] = cur;
        qm[d] = 0;
        push_op(1, 32'(cur), 16'h0050, 0);
        push_op(1, 32'(cur), 16'h0098, 0);
        for (int s = 0; s < 13; s++) begin
          if (!abort) begin
            push_op(0, 32'(cur + 2 * offs[s]), 16'h0, 0);
            if (s < 3 && cfg_sig[d][s] != sigx[s]) abort = 1;
          end
        end
        if (abort) begin
          push_op(1, 32'(cur), 16'h00FF, 3);
          stop = 1;
        end else begin
          push_op(1, 32'(cur), 16'h00FF, (d == n - 1) ? 2 : 1);
          x_base.push_back(32'(cur));
          x_size.push_back(32'(longint'(1) << cfg_e[d]));
          x_wb.push_back(32'((longint'(1) << cfg_w[d]) >> 1));
          x_c1.push_back({1'b0, cfg_c1[d]} + 17'd1);
          x_c2.push_back({1'b0, cfg_c2[d]} + 17'd1);
          x_s1.push_back({cfg_s1[d], 8'h00});
          x_s2.push_back({cfg_s2[d], 8'h00});
          x_die.push_back(d);
          cur = cur + (longint'(1) << cfg_e[d]);
        end
      end else begin
        cfg_base[d] = 64'h7FFF_0000_0000;
      end
    end
  endtask

  // per-clock reference compare
  int ev_tmr = -1;
  int ev_kind = 0;
  bit m_err = 0;
  bit re_prev = 0;
  int re_age = 0;
  logic [31:0] re_addr = '0;
  logic [31:0] l_base = '0, l_size = '0, l_wb = '0;
  logic [16:0] l_c1 = '0, l_c2 = '0;
  logic [23:0] l_s1 = '0, l_s2 = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit exp_rv, exp_dn;
      int dd;
      exp_rv = 0; exp_dn = 0;
      if (ev_tmr >= 1) begin
        ev_tmr = ev_tmr - 1;
        if (ev_tmr == 0) begin
          exp_rv = (ev_kind == 1 || ev_kind == 2);
          exp_dn = (ev_kind >= 2);
          if (ev_kind == 3) m_err = 1;
          ev_tmr = -1;
        end
      end
      chk(rec_valid == exp_rv, "R6 record strobe timing", rec_valid, exp_rv);
      chk(done == exp_dn, "R11 done timing", done, exp_dn);
      chk(sig_err == m_err, "R5 sig_err level", sig_err, m_err);

      if (rec_valid) begin
        if (x_base.size() == 0) begin
          chk(0, "R6 unexpected record", rec_base, 0);
        end else begin
          chk(rec_base == x_base[0], "R10 die base", rec_base, x_base[0]);
          chk(rec_die == CW'(x_die[0]), "R10 die index", rec_die, x_die[0]);
          chk(rec_size == x_size[0], "R7 device size", rec_size, x_size[0]);
          chk(rec_wbuf_words == x_wb[0], "R7 write buffer words", rec_wbuf_words, x_wb[0]);
          chk(rec_r1_blocks == x_c1[0], "R8 region1 blocks", rec_r1_blocks, x_c1[0]);
          chk(rec_r2_blocks == x_c2[0], "R8 region2 blocks", rec_r2_blocks, x_c2[0]);
          chk(rec_r1_bytes == x_s1[0], "R9 region1 block bytes", rec_r1_bytes, x_s1[0]);
          chk(rec_r2_bytes == x_s2[0], "R9 region2 block bytes", rec_r2_bytes, x_s2[0]);
          void'(x_base.pop_front()); void'(x_size.pop_front()); void'(x_wb.pop_front());
          void'(x_c1.pop_front()); void'(x_c2.pop_front()); void'(x_s1.pop_front());
          void'(x_s2.pop_front()); void'(x_die.pop_front());
        end
        l_base = rec_base; l_size = rec_size; l_wb = rec_wbuf_words;
        l_c1 = rec_r1_blocks; l_c2 = rec_r2_blocks; l_s1 = rec_r1_bytes; l_s2 = rec_r2_bytes;
      end else begin
        chk(rec_base == l_base && rec_size == l_size && rec_wbuf_words == l_wb &&
            rec_r1_blocks == l_c1 && rec_r2_blocks == l_c2 &&
            rec_r1_bytes == l_s1 && rec_r2_bytes == l_s2,
            "R12 record hold", rec_size, l_size);
      end

      chk(!(fl_we && fl_re), "R4 no strobe overlap", {fl_we, fl_re}, 0);

      if (fl_we) begin
        dd = find_die(fl_addr);
        if (dd >= 0 && longint'(fl_addr) == cfg_base[dd]) begin
          if (fl_wdata == 16'h0098) qm[dd] = 1;
          if (fl_wdata == 16'h00FF) qm[dd] = 0;
        end
        if (q_w.size() == 0) begin
          chk(0, "R3 unexpected write", fl_wdata, 0);
        end else begin
          chk(q_w[0] == 1'b1 && fl_addr == q_a[0] && fl_wdata == q_d[0],
              (q_d[0] == 16'h00FF) ? "R6 read-array write" : "R2 command write",
              {fl_addr, fl_wdata}, {q_a[0], q_d[0]});
          if (fl_wdata == 16'h00FF) begin
            ev_tmr = 2;
            ev_kind = q_k[0];
          end
          void'(q_w.pop_front()); void'(q_a.pop_front());
          void'(q_d.pop_front()); void'(q_k.pop_front());
        end
      end

      if (fl_re && !re_prev) begin
        re_addr = fl_addr;
        if (q_w.size() == 0) begin
          chk(0, "R3 unexpected read", fl_addr, 0);
        end else begin
          chk(q_w[0] == 1'b0 && fl_addr == q_a[0], "R3 read address order", fl_addr, q_a[0]);
          void'(q_w.pop_front()); void'(q_a.pop_front());
          void'(q_d.pop_front()); void'(q_k.pop_front());
        end
      end else if (fl_re) begin
        chk(fl_addr == re_addr, "R4 read address held", fl_addr, re_addr);
      end
      if (!fl_re && re_prev)
        chk(re_age == RD_WAIT, "R4 read strobe length", re_age, RD_WAIT);

      if (fl_re) begin
        re_age = re_prev ? re_age + 1 : 1;
        dd = find_die(fl_addr);
        if (re_age >= RD_WAIT && dd >= 0 && qm[dd])
          fdata = tval(dd, int'((longint'(fl_addr) - cfg_base[dd]) >> 1));
        else
          fdata = 16'hBAD0;
      end else begin
        fdata = 16'hBAD0;
      end
      re_prev = fl_re;
    end
  end

  task automatic run(input logic [31:0] b, input int n, input bit poke);
    plan(b, n);
    @(negedge clk); #1;
    m_err = 0;
    if (n == 0) begin ev_tmr = 1; ev_kind = 4; end
    first_base = b; die_count = CW'(n); start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      #1; start = 1'b1; first_base = 32'hDEAD_0000; die_count = CW'(3);
      @(negedge clk); #1; start = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      if (!busy && ev_tmr < 0 && q_w.size() == 0) break;
    end
    chk(q_w.size() == 0, "R3 all bus ops issued", q_w.size(), 0);
    chk(x_base.size() == 0, "R6 all records delivered", x_base.size(), 0);
    chk(busy == 1'b0, "R11 busy low after done", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(fl_we == 0 && fl_re == 0, "R1 bus idle in reset", {fl_we, fl_re}, 0);
    chk(done == 0 && sig_err == 0 && rec_valid == 0 && busy == 0, "R1 flags low in reset",
        {done, sig_err, rec_valid, busy}, 0);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(fl_we == 0 && fl_re == 0 && busy == 0 && done == 0, "R1 idle after reset",
        {fl_we, fl_re, busy, done}, 0);

    // single die
    set_die(0, 16, 6, 16'h0003, 16'h0080, 16'h0000, 16'h0001);
    run(32'h1000_0000, 1, 0);

    // three dies, base stepping, start poke while busy
    set_die(0, 20, 5, 16'h0007, 16'h0020, 16'h003E, 16'h0100);
    set_die(1, 12, 1, 16'hFFFF, 16'hFFFF, 16'h0100, 16'h0001);
    set_die(2, 24, 0, 16'h1234, 16'h5678, 16'h00FE, 16'h0002);
    run(32'h2000_0000, 3, 1);

    // signature wrong in the high byte of the third word of die 1
    set_die(0, 14, 4, 16'h0001, 16'h0040, 16'h0002, 16'h0010);
    set_die(1, 16, 6, 16'h0003, 16'h0080, 16'h0000, 16'h0001);
    cfg_sig[1][2] = 16'h0159;
    run(32'h3000_0000, 2, 0);

    // first signature word wrong on die 0, later dies skipped
    set_die(0, 16, 6, 16'h0003, 16'h0080, 16'h0000, 16'h0001);
    cfg_sig[0][0] = 16'h0000;
    set_die(1, 16, 6, 16'h0003, 16'h0080, 16'h0000, 16'h0001);
    set_die(2, 16, 6, 16'h0003, 16'h0080, 16'h0000, 16'h0001);
    run(32'h4000_0000, 3, 0);

    // zero dies
    run(32'h5000_0000, 0, 0);

    // good walk after an error clears sig_err
    set_die(0, 18, 3, 16'h000F, 16'h0200, 16'h0007, 16'h0040);
    set_die(1, 18, 3, 16'h000F, 16'h0200, 16'h0007, 16'h0040);
    run(32'h0800_0000, 2, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R11 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule